// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words that sits between two unrelated clock domains. A producer writes on its own clock; a consumer reads on a separate clock and sees each word in a registered data output. Four active-low status outputs report the fill level. The empty and almost-empty outputs belong to the read clock. The full and almost-full outputs belong to the write clock. Pointers cross between the domains as Gray codes through two-flop synchronizers, so the flags are always conservative.

The almost-empty threshold (n) and almost-full threshold (m) are each 18 bits wide. Each one is stored as a low 9-bit word and a high 9-bit word. A strap on the second write-enable pin is sampled while reset is held. When the strap is high, that pin is a second write enable. When it is low, the pin becomes a load strobe that steers the data path to the four threshold words. Through this strobe the words can be written and also read back in a fixed rotating order. An output-enable input gates the data output and reports whether it is being driven.

Top module: `prog_flag_fifo`

## Requirements
- R1: While `rst` is high (synchronous, active high), the block resets to `empty_n`=0, `full_n`=1, `ae_n`=0, `af_n`=1 and `q` = 0. It also sets each low threshold word to 0x007 and each high threshold word to 0x000, which gives n = m = 7.
- R2: Accepted words come out in write order. A read that is accepted on a `rclk` rising edge loads the next word into `q` on that same edge.
- R3: `full_n` is low exactly when DEPTH words are unread. A write attempted while `full_n` is low changes nothing.
- R4: `empty_n` is low exactly when no word is unread. A read attempted while `empty_n` is low leaves `q` unchanged.
- R5: `af_n` is low when the unread count is at least DEPTH − m, where m = high_word·512 + low_word of the almost-full threshold.
- R6: `ae_n` is low when the unread count is at most n, where n = high_word·512 + low_word of the almost-empty threshold.
- R7: If `wr_en_b_ld` is high during reset (dual-enable mode), a write needs both `wr_en_a` and `wr_en_b_ld` high, and a read needs both `rd_en_a` and `rd_en_b` high. A single enable has no effect.
- R8: If `wr_en_b_ld` is low during reset (load mode), the FIFO behaves as follows. `wr_en_a` with `wr_en_b_ld` low writes the FIFO. `wr_en_a` with `wr_en_b_ld` high writes a threshold word. Threshold words are written in the order empty-low (slot 0), empty-high (1), full-low (2), full-high (3), then the order wraps. Both read enables with `wr_en_b_ld` high return the threshold words in the same rotating order on `q` and leave the FIFO untouched.
- R9: When `out_en` is low, `q` reads 0 and `q_drv` is low. When `out_en` is high, `q` shows the output register and `q_drv` is high.
- R10: A write becomes visible on the read-side flags within 8 `rclk` cycles. A read becomes visible on the write-side flags within 8 `wclk` cycles. Each flag changes only on an edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| wr_en_a | input | 1 | Primary write enable |
| wr_en_b_ld | input | 1 | Mode strap during reset; afterwards second write enable or threshold load strobe |
| din | input | 9 | Write data or threshold word |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| out_en | input | 1 | Output enable for `q` |
| q | output | 9 | Registered read data, zero while disabled |
| q_drv | output | 1 | High while `q` is driven |
| empty_n | output | 1 | Empty flag, active low, read domain |
| full_n | output | 1 | Full flag, active low, write domain |
| ae_n | output | 1 | Almost-empty flag, active low, read domain |
| af_n | output | 1 | Almost-full flag, active low, write domain |

## Verification
The bench builds the block with ADDR_W = 4, which gives a depth of 16. With this depth the full boundary, the write that is refused at the full boundary, and both threshold crossings are reached within a few dozen operations. The default thresholds of 7 place the two almost flags in the middle of the range. Reprogramming them to n = 3 and m = 2 in load mode moves both crossings and exercises the rotating slot order. The two clocks run at the same rate with a fixed phase offset. This keeps the Gray-code synchronizers active on every transfer.

// File: rtl/pff_pkg.sv
package pff_pkg;

    localparam int WORD_W  = 9;
    localparam int THR_W   = 2 * WORD_W;
    localparam int N_SLOTS = 4;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        SLOT_AE_LO = 2'd0,
        SLOT_AE_HI = 2'd1,
        SLOT_AF_LO = 2'd2,
        SLOT_AF_HI = 2'd3
    } slot_e;

    typedef struct packed {
        logic [THR_W-1:0] ae;
        logic [THR_W-1:0] af;
    } thresh_t;

    localparam word_t LO_RESET = 9'h007;
    localparam word_t HI_RESET = 9'h000;

    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic slot_e next_slot(input slot_e s);
        return slot_e'(s + 2'd1);
    endfunction

endpackage

// File: rtl/pff_sync.sv
module pff_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage[gi] <= '0;
                end else if (gi == 0) begin
                    stage[gi] <= d;
                end else begin
                    stage[gi] <= stage[(gi == 0) ? 0 : gi-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/pff_ram.sv
module pff_ram
    import pff_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  word_t             wdata,
    input  logic [ADDR_W-1:0] raddr,
    output word_t             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    word_t mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pff_thresh_regs.sv
module pff_thresh_regs
    import pff_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load,
    input  word_t                        din,
    output logic [N_SLOTS-1:0][WORD_W-1:0] slot_q,
    output thresh_t                      thr
);
    slot_e wr_slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_slot <= SLOT_AE_LO;
        end else if (load) begin
            wr_slot <= next_slot(wr_slot);
        end
    end

    genvar gs;
    generate
        for (gs = 0; gs < N_SLOTS; gs++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_q[gs] <= (gs % 2 == 0) ? LO_RESET : HI_RESET;
                end else if (load && (wr_slot == slot_e'(gs))) begin
                    slot_q[gs] <= din;
                end
            end
        end
    endgenerate

    assign thr.ae = {slot_q[SLOT_AE_HI], slot_q[SLOT_AE_LO]};
    assign thr.af = {slot_q[SLOT_AF_HI], slot_q[SLOT_AF_LO]};
endmodule

// File: rtl/pff_wr_ctrl.sv
module pff_wr_ctrl
    import pff_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W:0]   rgray_s,
    input  logic [THR_W-1:0]  af_thr,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wbin,
    output logic [ADDR_W:0]   wgray,
    output logic              full_n,
    output logic              af_n
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SW    = THR_W + 1;

    logic          full_q;
    logic [PW-1:0] wnext;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] used_next;
    logic [SW-1:0] af_sum;

    always_comb begin
        we        = push && !full_q;
        wnext     = wbin + PW'(we);
        rbin_s    = PW'(from_gray(32'(rgray_s)));
        used_next = wnext - rbin_s;
        af_sum    = SW'(used_next) + SW'(af_thr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin   <= '0;
            wgray  <= '0;
            full_q <= 1'b0;
            af_n   <= 1'b1;
        end else begin
            wbin   <= wnext;
            wgray  <= PW'(to_gray(32'(wnext)));
            full_q <= (used_next == PW'(DEPTH));
            af_n   <= !(af_sum >= SW'(DEPTH));
        end
    end

    assign waddr  = wbin[ADDR_W-1:0];
    assign full_n = !full_q;
endmodule

// File: rtl/pff_rd_ctrl.sv
module pff_rd_ctrl
    import pff_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           pop_req,
    input  logic                           thr_rd,
    input  logic [ADDR_W:0]                wgray_s,
    input  logic [THR_W-1:0]               ae_thr,
    input  logic [N_SLOTS-1:0][WORD_W-1:0] slot_q,
    input  word_t                          mem_rdata,
    output logic [ADDR_W-1:0]              raddr,
    output logic [ADDR_W:0]                rbin,
    output logic [ADDR_W:0]                rgray,
    output word_t                          q_reg,
    output logic                           empty_n,
    output logic                           ae_n
);
    localparam int PW = ADDR_W + 1;

    logic          empty_q;
    logic          pop;
    logic [PW-1:0] rnext;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] avail_next;
    slot_e         rd_slot;

    always_comb begin
        pop        = pop_req && !empty_q;
        rnext      = rbin + PW'(pop);
        wbin_s     = PW'(from_gray(32'(wgray_s)));
        avail_next = wbin_s - rnext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin    <= '0;
            rgray   <= '0;
            empty_q <= 1'b1;
            ae_n    <= 1'b0;
            q_reg   <= '0;
            rd_slot <= SLOT_AE_LO;
        end else begin
            rbin    <= rnext;
            rgray   <= PW'(to_gray(32'(rnext)));
            empty_q <= (avail_next == '0);
            ae_n    <= !(THR_W'(avail_next) <= ae_thr);
            if (pop) begin
                q_reg <= mem_rdata;
            end else if (thr_rd) begin
                q_reg   <= slot_q[rd_slot];
                rd_slot <= next_slot(rd_slot);
            end
        end
    end

    assign raddr   = rbin[ADDR_W-1:0];
    assign empty_n = !empty_q;
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo
    import pff_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic        wclk,
    input  logic        rclk,
    input  logic        rst,
    input  logic        wr_en_a,
    input  logic        wr_en_b_ld,
    input  logic [8:0]  din,
    input  logic        rd_en_a,
    input  logic        rd_en_b,
    input  logic        out_en,
    output logic [8:0]  q,
    output logic        q_drv,
    output logic        empty_n,
    output logic        full_n,
    output logic        ae_n,
    output logic        af_n
);
    localparam int PW = ADDR_W + 1;

    logic dual_w;
    logic dual_r;
    logic push;
    logic thr_load;
    logic pop_req;
    logic thr_rd;
    logic we;

    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [PW-1:0]     wptr_bin;
    logic [PW-1:0]     rptr_bin;
    logic [PW-1:0]     wgray;
    logic [PW-1:0]     rgray;
    logic [PW-1:0]     wgray_s;
    logic [PW-1:0]     rgray_s;

    word_t                          mem_rdata;
    word_t                          q_reg;
    thresh_t                        thr;
    logic [N_SLOTS-1:0][WORD_W-1:0] slot_q;

    // Mode strap is latched in each domain while reset is held.
    always_ff @(posedge wclk) begin
        if (rst) begin
            dual_w <= wr_en_b_ld;
        end
    end

    always_ff @(posedge rclk) begin
        if (rst) begin
            dual_r <= wr_en_b_ld;
        end
    end

    always_comb begin
        push     = dual_w ? (wr_en_a && wr_en_b_ld) : (wr_en_a && !wr_en_b_ld);
        thr_load = !rst && !dual_w && wr_en_a && wr_en_b_ld;
        pop_req  = rd_en_a && rd_en_b && (dual_r || !wr_en_b_ld);
        thr_rd   = rd_en_a && rd_en_b && !dual_r && wr_en_b_ld;
    end

    pff_thresh_regs u_thr (
        .clk    (wclk),
        .rst    (rst),
        .load   (thr_load),
        .din    (din),
        .slot_q (slot_q),
        .thr    (thr)
    );

    pff_ram #(.ADDR_W(ADDR_W)) u_ram (
        .wclk  (wclk),
        .we    (we),
        .waddr (waddr),
        .wdata (din),
        .raddr (raddr),
        .rdata (mem_rdata)
    );

    pff_sync #(.W(PW), .STAGES(2)) u_sync_r2w (
        .clk (wclk),
        .rst (rst),
        .d   (rgray),
        .q   (rgray_s)
    );

    pff_sync #(.W(PW), .STAGES(2)) u_sync_w2r (
        .clk (rclk),
        .rst (rst),
        .d   (wgray),
        .q   (wgray_s)
    );

    pff_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .clk     (wclk),
        .rst     (rst),
        .push    (push),
        .rgray_s (rgray_s),
        .af_thr  (thr.af),
        .we      (we),
        .waddr   (waddr),
        .wbin    (wptr_bin),
        .wgray   (wgray),
        .full_n  (full_n),
        .af_n    (af_n)
    );

    pff_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
        .clk       (rclk),
        .rst       (rst),
        .pop_req   (pop_req),
        .thr_rd    (thr_rd),
        .wgray_s   (wgray_s),
        .ae_thr    (thr.ae),
        .slot_q    (slot_q),
        .mem_rdata (mem_rdata),
        .raddr     (raddr),
        .rbin      (rptr_bin),
        .rgray     (rgray),
        .q_reg     (q_reg),
        .empty_n   (empty_n),
        .ae_n      (ae_n)
    );

    assign q     = out_en ? q_reg : '0;
    assign q_drv = out_en;
endmodule

// File: rtl/pff_chk.sv
module pff_chk #(
    parameter int PW = 5
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst,
    input logic          full_n,
    input logic          empty_n,
    input logic          af_n,
    input logic          ae_n,
    input logic [PW-1:0] wptr,
    input logic [PW-1:0] rptr,
    input logic [PW-1:0] wgray
);
    p_no_overflow_r3: assert property (@(posedge wclk) disable iff (rst)
        !full_n |=> $stable(wptr));

    p_no_underflow_r4: assert property (@(posedge rclk) disable iff (rst)
        !empty_n |=> $stable(rptr));

    p_full_implies_af_r5: assert property (@(posedge wclk) disable iff (rst)
        !full_n |-> !af_n);

    p_empty_implies_ae_r6: assert property (@(posedge rclk) disable iff (rst)
        !empty_n |-> !ae_n);

    p_gray_one_step_r10: assert property (@(posedge wclk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1);
endmodule

bind prog_flag_fifo pff_chk #(.PW(ADDR_W + 1)) u_chk (
    .wclk    (wclk),
    .rclk    (rclk),
    .rst     (rst),
    .full_n  (full_n),
    .empty_n (empty_n),
    .af_n    (af_n),
    .ae_n    (ae_n),
    .wptr    (wptr_bin),
    .rptr    (rptr_bin),
    .wgray   (wgray)
);

// File: tb/tb_prog_flag_fifo.sv
module tb_prog_flag_fifo;
    localparam int AW = 4;
    localparam int D  = 1 << AW;

    logic       wclk = 1'b0;
    logic       rclk = 1'b0;
    logic       rst  = 1'b1;
    logic       wr_en_a = 1'b0;
    logic       wr_en_b_ld = 1'b1;
    logic [8:0] din = '0;
    logic       rd_en_a = 1'b0;
    logic       rd_en_b = 1'b0;
    logic       out_en = 1'b1;
    logic [8:0] q;
    logic       q_drv, empty_n, full_n, ae_n, af_n;

    prog_flag_fifo #(.ADDR_W(AW)) dut (
        .wclk(wclk), .rclk(rclk), .rst(rst),
        .wr_en_a(wr_en_a), .wr_en_b_ld(wr_en_b_ld), .din(din),
        .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .out_en(out_en),
        .q(q), .q_drv(q_drv), .empty_n(empty_n), .full_n(full_n),
        .ae_n(ae_n), .af_n(af_n)
    );

    always #2 wclk = ~wclk;
    initial begin
        #1;
        forever #2 rclk = ~rclk;
    end

    logic [8:0] model_q[$];
    logic [8:0] slot_m[4];
    logic [8:0] last_q;
    int         widx, ridx;
    logic       idle_b, dual;
    int         errs = 0;
    int         checks = 0;
    bit         done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int thr_n();
        return int'(slot_m[1]) * 512 + int'(slot_m[0]);
    endfunction

    function automatic int thr_m();
        return int'(slot_m[3]) * 512 + int'(slot_m[2]);
    endfunction

    // R10: every check is preceded by this settle window
    task automatic settle();
        repeat (8) @(negedge wclk);
    endtask

    task automatic check_flags(input string ctx);
        int cnt = model_q.size();
        chk(empty_n == (cnt != 0), {"R4 empty_n ", ctx}, empty_n, cnt != 0);
        chk(full_n == (cnt != D), {"R3 full_n ", ctx}, full_n, cnt != D);
        chk(ae_n == !(cnt <= thr_n()), {"R6 ae_n ", ctx}, ae_n, !(cnt <= thr_n()));
        chk(af_n == !(cnt >= D - thr_m()), {"R5 af_n ", ctx}, af_n, !(cnt >= D - thr_m()));
    endtask

    task automatic do_reset(input logic strap);
        rst = 1'b1;
        wr_en_b_ld = strap;
        repeat (4) @(negedge wclk);
        rst = 1'b0;
        model_q.delete();
        slot_m[0] = 9'h007; slot_m[1] = 9'h000;
        slot_m[2] = 9'h007; slot_m[3] = 9'h000;
        widx = 0; ridx = 0; last_q = '0;
        dual = strap; idle_b = strap;
        settle();
    endtask

    task automatic push_word(input logic [8:0] d, input logic a, input logic b);
        bit fires;
        @(negedge wclk);
        din = d; wr_en_a = a; wr_en_b_ld = b;
        @(negedge wclk);
        wr_en_a = 1'b0; wr_en_b_ld = idle_b;
        fires = dual ? (a && b) : (a && !b);
        if (fires && model_q.size() < D) model_q.push_back(d);
        settle();
    endtask

    task automatic pop_word(input logic a, input logic b, input string tag);
        logic [8:0] exp;
        @(negedge rclk);
        rd_en_a = a; rd_en_b = b;
        @(negedge rclk);
        rd_en_a = 1'b0; rd_en_b = 1'b0;
        if (a && b && model_q.size() > 0) exp = model_q.pop_front();
        else exp = last_q;
        chk(q == exp, tag, q, exp);
        last_q = exp;
        settle();
    endtask

    task automatic thr_write(input logic [8:0] d);
        @(negedge wclk);
        din = d; wr_en_a = 1'b1; wr_en_b_ld = 1'b1;
        @(negedge wclk);
        wr_en_a = 1'b0; wr_en_b_ld = idle_b;
        slot_m[widx] = d;
        widx = (widx + 1) % 4;
        settle();
    endtask

    task automatic thr_read();
        @(negedge wclk);
        wr_en_b_ld = 1'b1;
        @(negedge rclk);
        rd_en_a = 1'b1; rd_en_b = 1'b1;
        @(negedge rclk);
        rd_en_a = 1'b0; rd_en_b = 1'b0;
        chk(q == slot_m[ridx], "R8 threshold readback", q, slot_m[ridx]);
        last_q = slot_m[ridx];
        ridx = (ridx + 1) % 4;
        @(negedge wclk);
        wr_en_b_ld = idle_b;
        settle();
    endtask

    initial begin
        repeat (200000) @(posedge wclk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));

        // Dual-enable mode
        do_reset(1'b1);
        chk(q == 9'd0, "R1 q after reset", q, 0);
        check_flags("R1 reset");

        pop_word(1'b1, 1'b1, "R4 read while empty");
        check_flags("after empty read");
        push_word(9'h155, 1'b1, 1'b0);
        check_flags("R7 single write enable");
        pop_word(1'b0, 1'b1, "R7 single read enable");

        for (int i = 0; i < D; i++) begin
            push_word(9'((i * 37 + 5) & 9'h1FF), 1'b1, 1'b1);
            check_flags("fill");
        end
        push_word(9'h0AA, 1'b1, 1'b1);
        check_flags("R3 write while full");
        for (int i = 0; i < D; i++) begin
            pop_word(1'b1, 1'b1, "R2 drain order");
            check_flags("drain");
        end

        push_word(9'h1C3, 1'b1, 1'b1);
        pop_word(1'b1, 1'b1, "R2 single word");
        out_en = 1'b0;
        #1;
        chk(q == 9'd0, "R9 q disabled", q, 0);
        chk(q_drv == 1'b0, "R9 q_drv disabled", q_drv, 0);
        out_en = 1'b1;
        #1;
        chk(q == last_q, "R9 q enabled", q, last_q);
        chk(q_drv == 1'b1, "R9 q_drv enabled", q_drv, 1);

        for (int i = 0; i < 300; i++) begin
            int op = int'($urandom % 4);
            if (op < 2) push_word(9'($urandom), 1'b1, 1'b1);
            else if (op == 2) pop_word(1'b1, 1'b1, "R2 random read");
            else push_word(9'($urandom), 1'b0, 1'b1);
            check_flags("random");
        end

        // Load mode
        do_reset(1'b0);
        check_flags("R1 reset load mode");
        for (int i = 0; i < 4; i++) thr_read();
        thr_write(9'd3);
        thr_write(9'd0);
        thr_write(9'd2);
        thr_write(9'd0);
        check_flags("R8 new thresholds");
        for (int i = 0; i < 4; i++) thr_read();
        for (int i = 0; i < 15; i++) begin
            push_word(9'(100 + i), 1'b1, 1'b0);
            check_flags("R8 load-mode fill");
        end
        for (int i = 0; i < 15; i++) begin
            pop_word(1'b1, 1'b1, "R8 load-mode data");
            check_flags("R8 load-mode drain");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule